// File: doc/BRIEF.md
# Majority-Logic Adder with Two-Bit Carry Stride

This block is a purely combinational adder for two unsigned operands of even width plus a carry input. Every gate in it is written as a 3-input majority function or an inverter. AND is a majority gate with one input held low. OR is a majority gate with one input held high. This keeps the netlist in the same form as logic meant for majority-based cell fabrics, while staying ordinary synthesizable RTL.

The design has two separate parts:

- **Carry chain.** Each stage of the chain spans a pair of bit positions and takes its carry directly from the even position i to the even position i+2. The odd carry therefore never appears on the chain. Stages use per-bit propagate (OR of the operand bits) and generate (AND of the operand bits) signals.
- **Sum block.** This part takes the even carries from the chain. It rebuilds each odd carry locally as the majority of the two low operand bits and the even carry. It then forms both sum bits of the pair with three-input XORs.

Top module: `mga_adder`

## Requirements
- R1: For every input, `{carry_out, sum}` equals `op_a + op_b + carry_in` taken as a WIDTH+1 bit unsigned number.
- R2: `carry_out` is set exactly when the unsigned sum `op_a + op_b + carry_in` is at least 2^WIDTH.
- R3: With `op_a` all ones, `op_b` zero and `carry_in` 1, the carry ripples through every pair stage: `sum` is zero and `carry_out` is 1.
- R4: The carry entering each bit pair at position 2k equals the carry out of the low 2k bits, for k from 1 up to WIDTH/2. At the ports this shows as `sum[2k]` being `op_a[2k] ^ op_b[2k] ^` that carry.
- R5: `sum[0]` equals `op_a[0] ^ op_b[0] ^ carry_in`.
- R6: When both operand MSBs are 1, `carry_out` is 1. When both are 0, `carry_out` is 0. Lower bits do not affect this.
- R7: With both operands zero, `sum` equals `carry_in` in bit 0 and zero elsewhere, and `carry_out` is 0.
- R8: The adder is correct for any even WIDTH, in particular 4, 16 and 32. An odd WIDTH is rejected at elaboration.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a | input | WIDTH | First addend |
| op_b | input | WIDTH | Second addend |
| carry_in | input | 1 | Carry into bit 0 |
| sum | output | WIDTH | Sum modulo 2^WIDTH |
| carry_out | output | 1 | Carry out of the top bit pair |

## Verification
The hardest case to reach from the ports is a carry that must cross every two-bit stage. This happens only when every lower pair propagates and none generates or kills, so random operands almost never produce it at 32 bits. Directed vectors cover this: an all-ones operand added to a single injected carry, and low-ones patterns cut off at each even boundary. These vectors exercise the chain at each stage length. The 4-bit instance is driven through all 512 input combinations, which covers every propagate/generate/kill mix across its two stages.

// File: rtl/mga_pkg.sv
// Package: majority-logic primitives shared by every part of the adder.
// Assumes: nothing; all functions are pure combinational.
package mga_pkg;

    // Three-input majority vote
    function automatic logic maj3(input logic x, input logic y, input logic z);
        return (x & y) | (x & z) | (y & z);
    endfunction

    // Inverter primitive
    function automatic logic maj_not(input logic x);
        return ~x;
    endfunction

    // AND as majority with one input tied low
    function automatic logic maj_and(input logic x, input logic y);
        return maj3(x, y, 1'b0);
    endfunction

    // OR as majority with one input tied high
    function automatic logic maj_or(input logic x, input logic y);
        return maj3(x, y, 1'b1);
    endfunction

    // Two-input XOR from majority AND/OR and inverters
    function automatic logic maj_xor2(input logic x, input logic y);
        return maj_or(maj_and(x, maj_not(y)), maj_and(maj_not(x), y));
    endfunction

    // Three-input XOR built from two majority XORs
    function automatic logic maj_xor3(input logic x, input logic y, input logic z);
        return maj_xor2(maj_xor2(x, y), z);
    endfunction

endpackage

// File: rtl/mga_pg_gen.sv
// Module: per-bit propagate (OR) and generate (AND) signals.
// Assumes: WIDTH >= 1.
module mga_pg_gen
    import mga_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] op_a,
    input  logic [WIDTH-1:0] op_b,
    output logic [WIDTH-1:0] prop,
    output logic [WIDTH-1:0] gen
);
    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        // One majority OR and one majority AND per bit
        always_comb begin
            prop[i] = maj_or(op_a[i], op_b[i]);
            gen[i]  = maj_and(op_a[i], op_b[i]);
        end
    end
endmodule

// File: rtl/mga_carry_stage.sv
// Module: one two-bit carry stage; carry at even position i in,
// carry at position i+2 out. The odd carry stays inside the stage.
// Assumes: prop/gen index 0 is the lower bit of the pair.
module mga_carry_stage
    import mga_pkg::*;
(
    input  logic [1:0] prop,
    input  logic [1:0] gen,
    input  logic       c_lo,
    output logic       c_hi
);
    logic c_inner;

    // Carry out = g1 OR p1 AND (g0 OR p0 AND c_lo)
    always_comb begin
        c_inner = maj_or(gen[0], maj_and(prop[0], c_lo));
        c_hi    = maj_or(gen[1], maj_and(prop[1], c_inner));
    end
endmodule

// File: rtl/mga_carry_chain.sv
// Module: ripple chain of two-bit stages producing every even carry.
// Assumes: WIDTH is even; carry[0] is the adder's carry input.
module mga_carry_chain #(
    parameter int WIDTH  = 32,
    parameter int STAGES = WIDTH / 2
) (
    input  logic [WIDTH-1:0] prop,
    input  logic [WIDTH-1:0] gen,
    input  logic             carry_in,
    output logic [STAGES:0]  carry
);
    assign carry[0] = carry_in;

    for (genvar k = 0; k < STAGES; k++) begin : g_stage
        mga_carry_stage u_stage (
            .prop (prop[2*k+1 : 2*k]),
            .gen  (gen[2*k+1 : 2*k]),
            .c_lo (carry[k]),
            .c_hi (carry[k+1])
        );
    end
endmodule

// File: rtl/mga_sum_block.sv
// Module: sum bits for every pair; rebuilds the odd carry locally as
// majority(a_lo, b_lo, even carry).
// Assumes: WIDTH is even; carry[k] is the carry into bit 2k.
module mga_sum_block
    import mga_pkg::*;
#(
    parameter int WIDTH  = 32,
    parameter int STAGES = WIDTH / 2
) (
    input  logic [WIDTH-1:0]  op_a,
    input  logic [WIDTH-1:0]  op_b,
    input  logic [STAGES-1:0] carry,
    output logic [WIDTH-1:0]  sum
);
    for (genvar k = 0; k < STAGES; k++) begin : g_pair
        logic c_odd;
        // Local odd carry, then the two sum bits of the pair
        always_comb begin
            c_odd        = maj3(op_a[2*k], op_b[2*k], carry[k]);
            sum[2*k]     = maj_xor3(op_a[2*k], op_b[2*k], carry[k]);
            sum[2*k+1]   = maj_xor3(op_a[2*k+1], op_b[2*k+1], c_odd);
        end
    end
endmodule

// File: rtl/mga_adder.sv
// Module: top of the majority-logic adder with two-bit carry stride.
// Assumes: WIDTH even and >= 2; purely combinational, no clock.
module mga_adder #(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] op_a,
    input  logic [WIDTH-1:0] op_b,
    input  logic             carry_in,
    output logic [WIDTH-1:0] sum,
    output logic             carry_out
);
    localparam int STAGES = WIDTH / 2;

    if ((WIDTH % 2) != 0 || WIDTH < 2) begin : g_bad_width
        $error("mga_adder: WIDTH must be even and at least 2");
    end

    logic [WIDTH-1:0] prop;
    logic [WIDTH-1:0] gen;
    logic [STAGES:0]  chain_carry;

    mga_pg_gen #(.WIDTH(WIDTH)) u_pg (
        .op_a (op_a),
        .op_b (op_b),
        .prop (prop),
        .gen  (gen)
    );

    mga_carry_chain #(.WIDTH(WIDTH), .STAGES(STAGES)) u_chain (
        .prop     (prop),
        .gen      (gen),
        .carry_in (carry_in),
        .carry    (chain_carry)
    );

    mga_sum_block #(.WIDTH(WIDTH), .STAGES(STAGES)) u_sum (
        .op_a  (op_a),
        .op_b  (op_b),
        .carry (chain_carry[STAGES-1:0]),
        .sum   (sum)
    );

    assign carry_out = chain_carry[STAGES];
endmodule

// File: rtl/mga_adder_checker.sv
// Module: assertion checker bound to mga_adder; relates the ports and
// the chain's even carries to arithmetic reference values.
// Assumes: combinational design, so immediate assertions are used.
module mga_adder_checker #(
    parameter int WIDTH  = 32,
    parameter int STAGES = WIDTH / 2
) (
    input logic [WIDTH-1:0] op_a,
    input logic [WIDTH-1:0] op_b,
    input logic             carry_in,
    input logic [WIDTH-1:0] sum,
    input logic             carry_out,
    input logic [STAGES:0]  even_carry
);
    logic [WIDTH:0] ref_total;

    // Arithmetic reference for the full result
    always_comb ref_total = {1'b0, op_a} + {1'b0, op_b} + {{WIDTH{1'b0}}, carry_in};

    // Whole-result and MSB-pair properties
    always_comb begin
        p_sum_match_r1: assert ({carry_out, sum} == ref_total)
            else $error("R1 result mismatch");
        p_overflow_r2: assert (carry_out == ref_total[WIDTH])
            else $error("R2 carry_out mismatch");
        p_lsb_r5: assert (sum[0] == (op_a[0] ^ op_b[0] ^ carry_in))
            else $error("R5 lsb mismatch");
        if (op_a[WIDTH-1] && op_b[WIDTH-1])
            p_gen_top_r6: assert (carry_out) else $error("R6 generate");
        if (!op_a[WIDTH-1] && !op_b[WIDTH-1])
            p_kill_top_r6: assert (!carry_out) else $error("R6 kill");
        if (op_a == '0 && op_b == '0)
            p_zero_ops_r7: assert (!carry_out && sum == {{(WIDTH-1){1'b0}}, carry_in})
                else $error("R7 zero operands");
    end

    // Each even carry matches the carry out of the low 2k bits
    for (genvar k = 1; k <= STAGES; k++) begin : g_even
        localparam int LOW = 2 * k;
        logic [LOW:0] low_total;
        always_comb begin
            low_total = {1'b0, op_a[LOW-1:0]} + {1'b0, op_b[LOW-1:0]}
                      + {{LOW{1'b0}}, carry_in};
            p_even_carry_r4: assert (even_carry[k] == low_total[LOW])
                else $error("R4 even carry mismatch");
        end
    end
endmodule

bind mga_adder mga_adder_checker #(.WIDTH(WIDTH)) u_mga_chk (
    .op_a       (op_a),
    .op_b       (op_b),
    .carry_in   (carry_in),
    .sum        (sum),
    .carry_out  (carry_out),
    .even_carry (chain_carry)
);

// File: tb/mga_adder_bench.sv
// Bench: drives 4-, 16- and 32-bit adders and compares against A+B+cin.
module mga_adder_bench;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #4 clk = ~clk;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    logic [3:0]  a4, b4, s4;
    logic [15:0] a16, b16, s16;
    logic [31:0] a32, b32, s32;
    logic        ci4, ci16, ci32, co4, co16, co32;

    mga_adder #(.WIDTH(4)) u_mga_adder_w4 (
        .op_a(a4), .op_b(b4), .carry_in(ci4), .sum(s4), .carry_out(co4));
    mga_adder #(.WIDTH(16)) u_mga_adder_w16 (
        .op_a(a16), .op_b(b16), .carry_in(ci16), .sum(s16), .carry_out(co16));
    mga_adder #(.WIDTH(32)) u_mga_adder (
        .op_a(a32), .op_b(b32), .carry_in(ci32), .sum(s32), .carry_out(co32));

    // Reference: {carry, sum} of a w-bit add, zero above bit w
    function automatic logic [63:0] ref_add(input logic [31:0] a, input logic [31:0] b,
                                            input logic ci, input int w);
        logic [63:0] mask;
        logic [63:0] t;
        mask = (64'd1 << w) - 64'd1;
        t = ({32'b0, a} & mask) + ({32'b0, b} & mask) + {63'b0, ci};
        return t & ((mask << 1) | 64'd1);
    endfunction

    task automatic check(input string tag, input logic [63:0] got, input logic [63:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    // Apply one vector to all widths and compare at the falling edge
    task automatic run_vec(input string tag, input logic [31:0] a, input logic [31:0] b,
                           input logic ci);
        @(posedge clk);
        #1;
        a4 = a[3:0];   b4 = b[3:0];   ci4 = ci;
        a16 = a[15:0]; b16 = b[15:0]; ci16 = ci;
        a32 = a;       b32 = b;       ci32 = ci;
        @(negedge clk);
        check({tag, " w4"},  {59'b0, co4, s4},   ref_add(a, b, ci, 4));
        check({tag, " w16"}, {47'b0, co16, s16}, ref_add(a, b, ci, 16));
        check({tag, " w32"}, {31'b0, co32, s32}, ref_add(a, b, ci, 32));
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2718));
        a4 = '0; b4 = '0; ci4 = 1'b0;
        a16 = '0; b16 = '0; ci16 = 1'b0;
        a32 = '0; b32 = '0; ci32 = 1'b0;
        repeat (3) @(posedge clk);
        rst_n = 1'b1;

        // R7: zero operands after reset, both carry-in values
        @(negedge clk);
        check("R7 idle w32", {31'b0, co32, s32}, 64'd0);
        run_vec("R7 zero ci0", 32'd0, 32'd0, 1'b0);
        run_vec("R7 zero ci1", 32'd0, 32'd0, 1'b1);

        // R3: carry travels every stage
        run_vec("R3 full ripple", 32'hFFFF_FFFF, 32'd0, 1'b1);
        run_vec("R3 full ripple swap", 32'd0, 32'hFFFF_FFFF, 1'b1);
        @(negedge clk);
        check("R3 w32 sum zero", {32'b0, s32}, 64'd0);
        check("R3 w32 carry", {63'b0, co32}, 64'd1);

        // R4: carry stops at each even boundary
        for (int k = 1; k <= 16; k++) begin
            logic [31:0] low;
            low = (k == 16) ? 32'hFFFF_FFFF : ((32'd1 << (2 * k)) - 32'd1);
            run_vec("R4 boundary", low, 32'd1, 1'b0);
            check("R4 bit 2k", {63'b0, (k < 16) ? s32[2*k] : co32}, 64'd1);
        end

        // R6: MSB generate and kill regardless of low bits
        run_vec("R6 gen", 32'h8000_0000, 32'h8000_0000, 1'b0);
        run_vec("R6 kill", 32'h7FFF_FFFF, 32'h7FFF_FFFF, 1'b1);
        // R2: overflow boundary
        run_vec("R2 just below", 32'hFFFF_FFFE, 32'd1, 1'b0);
        run_vec("R2 just at", 32'hFFFF_FFFE, 32'd1, 1'b1);
        // R5: lsb toggles
        run_vec("R5 lsb", 32'd1, 32'd0, 1'b1);
        run_vec("R5 lsb b", 32'd0, 32'd1, 1'b0);

        // R8, R1: exhaustive 4-bit
        for (int v = 0; v < 512; v++)
            run_vec("R8 R1 exhaustive", {28'b0, 4'(v >> 1)}, {28'b0, 4'(v >> 5)}, v[0]);

        // R1: random operands for 16 and 32 bits
        for (int n = 0; n < 3000; n++)
            run_vec("R1 random", $urandom, $urandom, 1'($urandom));

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule